// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a clause-22 MDIO master. Software issues one management access by writing a single 32-bit command word. The word carries the operation, the PHY address, the register address and, for a write, sixteen data bits. The controller then sends the complete frame on the management clock and data pins. While the frame runs, an idle flag is low. When the flag returns high, a read result is available in the low half of the readback word.

The management clock is the system clock divided by one of four fixed ratios. A 2-bit select input chooses the ratio, so the clock stays below the 2.5 MHz limit over the whole system clock range: /64 for clocks above 80 MHz, /32 above 40 MHz, /16 above 20 MHz, and /8 for slower clocks. A port enable gates all activity. Commands are refused while it is low, and clearing it during a frame stops the frame at once.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `mgmt_word` is 0.
- R2: During a frame, the `mdc` period is 8<<`clk_sel` system clocks, with equal high and low halves. `clk_sel` is sampled when the command is accepted: 0 gives /8, 1 gives /16, 2 gives /32, 3 gives /64.
- R3: A write command puts 64 bits on `mdio_o`, MSB first, with `mdio_oe` high throughout. The bits are 32 ones, then 01, then op 01, then PHY address `cmd_word[27:23]`, then register address `cmd_word[22:18]`, then turnaround 10, then data `cmd_word[15:0]`. `cmd_word[29]`=1 selects a read (op 10); 0 selects a write. Each bit is valid at the rising edge of `mdc`, and data changes after the falling edge.
- R4: In a read frame, `mdio_oe` is 0 from the first turnaround bit (bit 46) to the end of the frame. The controller samples `mdio_i` at `mdc` rising edges of bits 48..63, MSB first.
- R5: `idle` goes low in the cycle after an accepted `cmd_wr`. It stays low for exactly 64 `mdc` periods.
- R6: `mgmt_word` holds the last accepted command word. When a read completes, its low 16 bits are replaced with the captured data. A write leaves it unchanged.
- R7: A `cmd_wr` while a frame is running is ignored. The running frame and `mgmt_word` are unaffected.
- R8: While `port_en` is 0, commands are ignored. Clearing `port_en` during a frame drives `mdc` and `mdio_oe` low and `idle` high on the next cycle, and leaves `mgmt_word` unchanged.
- R9: Read data 0xFFFF is captured and reported like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Management port enable |
| clk_sel | input | 2 | Clock divide select (/8, /16, /32, /64) |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| mgmt_word | output | 32 | Readback: last command, low half holds read data |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The tests send write frames at the /8, /32 and /64 settings and read frames at /16 and /64. Comparing every driven bit at each `mdc` rising edge separates field order and op encoding errors from divider errors, which the period and high-time checks catch. Reads with a mixed pattern and with 0xFFFF show whether capture order and the release of the data pin are right. A second command in mid-frame, a command with the port disabled, and a mid-frame disable each show whether the refusal and abort paths leave the frame and the readback word intact.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int BODY_BITS  = 32;
  localparam int FRAME_BITS = PRE_BITS + BODY_BITS;
  localparam int TA_FIRST   = PRE_BITS + 14;
  localparam int DATA_FIRST = PRE_BITS + 16;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int RD_BIT     = 29;
  localparam int PHY_LSB    = 23;
  localparam int REG_LSB    = 18;

  function automatic logic [BODY_BITS-1:0] build_body(input logic [31:0] cmd);
    logic rd;
    rd = cmd[RD_BIT];
    return {2'b01, (rd ? 2'b10 : 2'b01), cmd[PHY_LSB +: ADDR_W], cmd[REG_LSB +: ADDR_W],
            2'b10, (rd ? {DATA_W{1'b0}} : cmd[DATA_W-1:0])};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int BASE_HALF = 4,
  localparam int CNT_W = $clog2(BASE_HALF * 8)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       mdc,
  output logic       rise,
  output logic       fall
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   half_m1;
  logic             edge_now;

  always_comb begin
    half_m1  = (CNT_W+1)'(BASE_HALF << sel) - 1'b1;
    edge_now = run && ({1'b0, cnt} == half_m1);
    rise     = edge_now && !mdc;
    fall     = edge_now && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (edge_now) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_mdc_low_when_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt} <= half_m1);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int NBITS = FRAME_BITS,
  localparam int IDX_W = $clog2(NBITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 abort,
  input  logic                 is_read,
  input  logic [BODY_BITS-1:0] body,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic [DATA_W-1:0]    rd_data
);
  logic [NBITS-1:0] sh;
  logic [IDX_W-1:0] idx;
  logic             rd_q;
  logic [IDX_W-1:0] idx_nx;

  assign idx_nx = idx + 1'b1;
  assign done   = busy && fall && (idx == IDX_W'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sh      <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (abort) begin
      busy    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        sh      <= {{(NBITS-BODY_BITS){1'b1}}, body};
        idx     <= '0;
        rd_q    <= is_read;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise && rd_q && idx >= IDX_W'(DATA_FIRST))
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (done) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          idx <= idx_nx;
          sh  <= sh << 1;
          if (rd_q && idx_nx >= IDX_W'(TA_FIRST)) begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
          end else begin
            mdio_oe <= 1'b1;
            mdio_o  <= sh[NBITS-2];
          end
        end
      end
    end
  end

  assert_released_in_read_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && idx >= IDX_W'(TA_FIRST)) |-> !mdio_oe);
  assert_driven_in_write_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_q) |-> mdio_oe);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int BASE_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        port_en,
  input  logic [1:0]  clk_sel,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  output logic [31:0] mgmt_word,
  output logic        idle,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              busy, done, rise, fall, accept;
  logic [1:0]        sel_q;
  logic              rd_q;
  logic [DATA_W-1:0] rd_data;

  assign accept = cmd_wr && port_en && !busy;
  assign idle   = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mgmt_word <= '0;
      sel_q     <= '0;
      rd_q      <= 1'b0;
    end else if (accept) begin
      mgmt_word <= cmd_word;
      sel_q     <= clk_sel;
      rd_q      <= cmd_word[RD_BIT];
    end else if (port_en && done && rd_q) begin
      mgmt_word[DATA_W-1:0] <= {rd_data[DATA_W-2:0], 1'b0} >> 1 | rd_data;
    end
  end

  mdio_clkdiv #(.BASE_HALF(BASE_HALF)) u_div (
    .clk(clk), .rst(rst), .run(busy && port_en), .sel(sel_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst(rst), .start(accept), .abort(!port_en),
    .is_read(cmd_word[RD_BIT]), .body(build_body(cmd_word)),
    .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data)
  );

  assert_idle_not_driving_R1: assert property (@(posedge clk) disable iff (rst)
    idle |-> !mdio_oe);
  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!idle && cmd_wr) |=> (mgmt_word[31:DATA_W] == $past(mgmt_word[31:DATA_W])));
  assert_disable_stops_R8: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (idle && !mdc));
  assert_accept_starts_R5: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_wr && port_en) |=> !idle);
endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        port_en = 1'b1;
  logic [1:0]  clk_sel = 2'd0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [31:0] mgmt_word;
  logic        idle, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  int checks = 0, errors = 0, m_checks = 0, m_errors = 0;

  logic [63:0] exp_vec = '0;
  logic        exp_rd = 1'b0;
  logic [1:0]  exp_sel = 2'd0;
  logic [15:0] phy_data = '0;
  logic        abort_exp = 1'b0;

  always #4 clk = !clk;

  mdio_mgmt_master u0 (
    .clk(clk), .rst(rst), .port_en(port_en), .clk_sel(clk_sel),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word), .mgmt_word(mgmt_word),
    .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic logic [63:0] frame_of(input logic [31:0] c);
    return {32'hFFFF_FFFF, 2'b01, (c[29] ? 2'b10 : 2'b01), c[27:23], c[22:18],
            2'b10, (c[29] ? 16'h0 : c[15:0])};
  endfunction

  // Behavioural per-clock model of the pins during a frame
  logic        prev_idle = 1'b1, prev_mdc = 1'b0, frame_on = 1'b0, m_rd = 1'b0;
  logic [63:0] m_vec = '0;
  int          rc = 0, cyc = 0, hl = 0, ilow = 0, m_div = 8;

  task automatic mchk(input bit ok, input string req, input int act, input int expv);
    m_checks++;
    if (!ok) begin
      m_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_idle && !idle) begin
        frame_on = 1'b1; rc = 0; cyc = 0; hl = 0; ilow = 0;
        m_vec = exp_vec; m_rd = exp_rd; m_div = 8 << exp_sel;
      end
      if (!idle) ilow++;
      if (frame_on) begin
        cyc++;
        if (mdc) hl++;
        if (mdc && !prev_mdc) begin
          if (rc > 0) mchk(cyc == m_div, "R2 period", cyc, m_div);
          if (rc < 64) begin
            if (!m_rd || rc < 46)
              mchk(mdio_oe && mdio_o == m_vec[63-rc], "R3 bit", {mdio_oe, mdio_o},
                   {1'b1, m_vec[63-rc]});
            else
              mchk(!mdio_oe, "R4 released", mdio_oe, 0);
          end
          rc++; cyc = 0;
        end
        if (!mdc && prev_mdc) begin
          if (!abort_exp) mchk(hl == m_div / 2, "R2 high time", hl, m_div / 2);
          hl = 0;
        end
      end
      if (!prev_idle && idle && frame_on) begin
        if (!abort_exp) begin
          mchk(ilow == 64 * m_div, "R5 busy length", ilow, 64 * m_div);
          mchk(rc == 64, "R5 edge count", rc, 64);
        end
        frame_on = 1'b0;
      end
      prev_idle = idle;
      prev_mdc  = mdc;
    end
  end

  // PHY model: drives read data after each falling mdc edge
  always @(negedge mdc)
    if (frame_on && m_rd && rc >= 48 && rc <= 63) mdio_i <= phy_data[63-rc];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic issue(input logic [31:0] c, input logic [1:0] s, input bit expect_start);
    @(negedge clk);
    if (expect_start) begin
      exp_vec = frame_of(c); exp_rd = c[29]; exp_sel = s;
    end
    cmd_word = c; clk_sel = s; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    if (expect_start) chk(idle == 1'b0, "R5 start", idle, 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 6000 && !idle; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] c;
    repeat (5) @(negedge clk);
    chk(idle && !mdc && !mdio_oe && mgmt_word == 0, "R1 during reset",
        {idle, mdc, mdio_oe, mgmt_word[28:0]}, 32'h8000_0000);
    rst = 1'b0;
    @(negedge clk);
    chk(idle && !mdc && !mdio_oe && mgmt_word == 0, "R1 after reset",
        {idle, mdc, mdio_oe, mgmt_word[28:0]}, 32'h8000_0000);

    // R3 R2 write at /8
    c = {2'b01, 2'b01, 5'd5, 5'h1A, 2'b10, 16'hA5C3};
    issue(c, 2'd0, 1); wait_idle();
    chk(mgmt_word == c, "R6 write readback", mgmt_word, c);

    // R4 R6 read at /16
    phy_data = 16'h1234;
    c = {2'b01, 2'b10, 5'd17, 5'd2, 2'b10, 16'hBEEF};
    issue(c, 2'd1, 1); wait_idle();
    chk(mgmt_word == {c[31:16], 16'h1234}, "R6 read data", mgmt_word, {c[31:16], 16'h1234});

    // R9 all ones at /64
    phy_data = 16'hFFFF;
    c = {2'b01, 2'b10, 5'd31, 5'd31, 2'b10, 16'h0000};
    issue(c, 2'd3, 1); wait_idle();
    chk(mgmt_word == {c[31:16], 16'hFFFF}, "R9 ffff capture", mgmt_word, {c[31:16], 16'hFFFF});

    // R7 second command mid-frame at /32
    c = {2'b01, 2'b01, 5'd0, 5'd4, 2'b10, 16'h0F0F};
    issue(c, 2'd2, 1);
    repeat (300) @(negedge clk);
    issue(32'h7FFF_FFFF, 2'd0, 0);
    chk(!idle, "R7 frame continues", idle, 0);
    wait_idle();
    chk(mgmt_word == c, "R7 readback kept", mgmt_word, c);

    // R8 command while disabled
    port_en = 1'b0;
    issue({2'b01, 2'b01, 5'd1, 5'd1, 2'b10, 16'h1111}, 2'd0, 0);
    repeat (20) @(negedge clk);
    chk(idle && !mdc && !mdio_oe && mgmt_word == c, "R8 disabled ignored",
        mgmt_word, c);
    port_en = 1'b1;

    // R8 abort mid read frame
    phy_data = 16'h5A5A;
    c = {2'b01, 2'b10, 5'd9, 5'd3, 2'b10, 16'hCAFE};
    issue(c, 2'd1, 1);
    repeat (700) @(negedge clk);
    abort_exp = 1'b1;
    port_en = 1'b0;
    @(negedge clk);
    chk(idle && !mdc && !mdio_oe, "R8 abort pins", {idle, mdc, mdio_oe}, 3'b100);
    chk(mgmt_word == c, "R8 abort readback", mgmt_word, c);
    repeat (5) @(negedge clk);
    port_en = 1'b1;
    repeat (2) @(negedge clk);
    abort_exp = 1'b0;

    // R2 R3 write at /64 after abort, PHY address of all ones
    c = {2'b01, 2'b01, 5'd31, 5'd0, 2'b10, 16'h8001};
    issue(c, 2'd3, 1); wait_idle();
    chk(mgmt_word == c, "R6 write after abort", mgmt_word, c);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks + m_checks, errors + m_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + m_checks + 1,
             errors + m_errors + 1);
    $finish;
  end
endmodule